// File: doc/BRIEF.md
# Page Translation Lookaside Buffer

This block keeps a small, fully associative store of recently used page translations for the one address space that is currently active. Each request on the lookup port carries a virtual address and a read/write flag. One cycle later the block answers with a hit and the translated physical address, a permission fault, or a miss. The hit answer also carries the page's access rights and its cacheable and bufferable attributes.

After a miss, an external table walker reads the page descriptor and installs it through the fill port. The page size is 64 KB. The low 16 address bits form the page offset, and the bits above them form the page number, which is the tag. When the operating system switches tasks, it pulses the flush input so that no translation from the retiring task stays in the store.

Top module: `xlat_tlb`

## Requirements
- R1: After reset all entries are invalid and every response output is 0. A lookup issued right after reset misses.
- R2: A lookup presented in cycle N is answered in cycle N+1 with `rsp_valid` high. `rsp_valid` is low in the cycle after a cycle with no request. The answer reflects the store as it stood at the start of cycle N, so a fill or flush made in that same cycle does not affect it.
- R3: On a hit, `rsp_paddr` is the stored frame number followed by `lk_vaddr[15:0]` unchanged.
- R4: On a hit, `rsp_perm`, `rsp_cacheable` and `rsp_bufferable` return the values that were stored by the fill.
- R5: The permission field has two bits. Bit 0 allows reads and bit 1 allows writes. A matching entry that does not allow the requested access gives `rsp_fault` = 1 and `rsp_hit` = 0. In that case the address and attribute outputs are 0.
- R6: A lookup that matches no valid entry gives `rsp_valid` = 1 and `rsp_hit` = `rsp_fault` = 0. The address and attribute outputs are 0.
- R7: A fill for a page number that is already held overwrites that entry. The lookup then returns the new data, and no second copy is created.
- R8: A fill for a new page number goes into the lowest-numbered invalid entry when any entry is invalid.
- R9: When every entry is valid, a new fill replaces the entry chosen by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping at 64, only on such replacements. A flush does not move the pointer.
- R10: A flush invalidates every entry from the next cycle on. A lookup of any earlier page then misses.
- R11: A flush and a fill in the same cycle: the flush wins and the fill is discarded.
- R12: The store holds 64 distinct translations at once, and all of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 16 | Virtual page number to install |
| fill_pfn | input | 16 | Physical frame number for that page |
| fill_perm | input | 2 | Bit 0 read allowed, bit 1 write allowed |
| fill_cacheable | input | 1 | Cacheable attribute of the page |
| fill_bufferable | input | 1 | Write-buffer attribute of the page |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response to the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_fault | output | 1 | Translation found but access forbidden |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_perm | output | 2 | Permission bits of the hit entry |
| rsp_cacheable | output | 1 | Cacheable attribute of the hit entry |
| rsp_bufferable | output | 1 | Write-buffer attribute of the hit entry |

## Verification
Several properties are checked on every cycle:
- the response follows the request by exactly one cycle;
- hit and fault never occur together;
- the page offset passes through untouched on a hit;
- a miss returns a zero address;
- no lookup ever matches two entries;
- the store is empty in the cycle after a flush.

Some behaviours only the bench's scenarios can show, because they depend on history. These are:
- which entry a fill picks, that is, the lowest free slot first and then round-robin with a pointer that survives flushes;
- that an overwrite replaces stale data;
- that a flush discards a same-cycle fill;
- the exact frame number and attributes returned.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation lookaside buffer.
// Assumes a two-bit permission field: bit 0 grants read, bit 1 grants write.
package tlb_pkg;
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;

    typedef struct packed {
        logic [1:0] perm;
        logic       cacheable;
        logic       bufferable;
    } attr_t;

    // True when the permission field allows the requested access.
    function automatic logic access_ok(input logic [1:0] perm, input logic is_write);
        return is_write ? perm[PERM_WR] : perm[PERM_RD];
    endfunction
endpackage

// File: rtl/tlb_match.sv
// Parallel tag comparator: one equality compare per entry, qualified by its
// valid bit. Assumes the store never holds two valid copies of one tag.
module tlb_match #(
    parameter int ENTRIES = 64,
    parameter int KEY_W   = 16
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [KEY_W-1:0]   tags [ENTRIES],
    input  logic [KEY_W-1:0]   key,
    output logic [ENTRIES-1:0] hits
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // Compare one entry's tag with the key.
        assign hits[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/tlb_victim.sv
// Replacement selector: the lowest-numbered invalid entry when one exists,
// otherwise a round-robin pointer that advances only when a valid entry is
// replaced. Assumes alloc is asserted only for fills that create a new entry.
module tlb_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic               alloc,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] first_free;
    logic             any_free;

    // Find the lowest-numbered invalid entry.
    always_comb begin
        first_free = '0;
        any_free   = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free   = 1'b1;
                first_free = IDX_W'(i);
            end
        end
    end

    // Choose between the free slot and the rotating pointer.
    assign victim = any_free ? first_free : rr_q;

    // Advance the pointer each time a valid entry is evicted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (alloc && !any_free)
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
endmodule

// File: rtl/xlat_tlb.sv
// Fully associative translation lookaside buffer for one address space.
// A lookup is answered one cycle later with hit, permission fault or miss.
// A fill installs a walker-supplied descriptor and overwrites an existing
// copy of the same page. A flush clears every entry and wins over a fill in
// the same cycle. Assumes fill data comes from a valid page descriptor.
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 16,
    parameter int ENTRIES   = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lk_valid,
    input  logic [VA_W-1:0]           lk_vaddr,
    input  logic                      lk_write,
    input  logic                      fill_valid,
    input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
    input  logic [PA_W-PAGE_BITS-1:0] fill_pfn,
    input  logic [1:0]                fill_perm,
    input  logic                      fill_cacheable,
    input  logic                      fill_bufferable,
    input  logic                      flush,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic                      rsp_fault,
    output logic [PA_W-1:0]           rsp_paddr,
    output logic [1:0]                rsp_perm,
    output logic                      rsp_cacheable,
    output logic                      rsp_bufferable
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PFN_W = PA_W - PAGE_BITS;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    attr_t              attr_q [ENTRIES];

    logic [ENTRIES-1:0] lk_hits;
    logic [ENTRIES-1:0] fill_hits;
    logic [IDX_W-1:0]   victim;
    logic [IDX_W-1:0]   wr_idx;
    logic               fill_take;
    logic               fill_new;
    logic [PFN_W-1:0]   sel_pfn;
    attr_t              sel_attr;
    logic               lk_any;
    logic               allowed;

    // Convert a one-hot vector to its index (0 when empty).
    function automatic logic [IDX_W-1:0] onehot_idx(input logic [ENTRIES-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (v[i]) r = r | IDX_W'(i);
        return r;
    endfunction

    tlb_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_lk_match (
        .valid (valid_q),
        .tags  (tag_q),
        .key   (lk_vaddr[VA_W-1:PAGE_BITS]),
        .hits  (lk_hits)
    );

    tlb_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_fill_match (
        .valid (valid_q),
        .tags  (tag_q),
        .key   (fill_vpn),
        .hits  (fill_hits)
    );

    assign fill_take = fill_valid && !flush;
    assign fill_new  = fill_take && !(|fill_hits);

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (valid_q),
        .alloc  (fill_new),
        .victim (victim)
    );

    // Write slot: the existing copy of the page, else the chosen victim.
    assign wr_idx = (|fill_hits) ? onehot_idx(fill_hits) : victim;

    // Valid bits: cleared by reset or flush, set by an accepted fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            valid_q <= '0;
        else if (fill_valid)
            valid_q[wr_idx] <= 1'b1;
    end

    // Entry payload: written on an accepted fill, no reset needed.
    always_ff @(posedge clk) begin
        if (fill_take) begin
            tag_q[wr_idx]  <= fill_vpn;
            pfn_q[wr_idx]  <= fill_pfn;
            attr_q[wr_idx] <= '{perm: fill_perm, cacheable: fill_cacheable,
                                bufferable: fill_bufferable};
        end
    end

    // Gather the payload of the matching entry by masked OR.
    always_comb begin
        sel_pfn  = '0;
        sel_attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hits[i]) begin
                sel_pfn  = sel_pfn | pfn_q[i];
                sel_attr = attr_t'(sel_attr | attr_q[i]);
            end
        end
    end

    assign lk_any  = |lk_hits;
    assign allowed = access_ok(sel_attr.perm, lk_write);

    // Register the lookup answer one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_fault      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_perm       <= '0;
            rsp_cacheable  <= 1'b0;
            rsp_bufferable <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_any && allowed;
            rsp_fault <= lk_valid && lk_any && !allowed;
            if (lk_valid && lk_any && allowed) begin
                rsp_paddr      <= {sel_pfn, lk_vaddr[PAGE_BITS-1:0]};
                rsp_perm       <= sel_attr.perm;
                rsp_cacheable  <= sel_attr.cacheable;
                rsp_bufferable <= sel_attr.bufferable;
            end else begin
                rsp_paddr      <= '0;
                rsp_perm       <= '0;
                rsp_cacheable  <= 1'b0;
                rsp_bufferable <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xlat_tlb_checker.sv
// Property checker for xlat_tlb, attached through bind. Observes ports and
// the internal valid and match vectors; drives nothing.
module xlat_tlb_checker #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 16,
    parameter int ENTRIES   = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               flush,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic [ENTRIES-1:0] lk_hits,
    input logic [ENTRIES-1:0] valid_q
);
    // R2: every request is answered in the next cycle.
    p_answer_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R2: no answer without a request.
    p_quiet_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R3: the page offset passes through on a hit.
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0]));

    // R5: hit and fault never occur together.
    p_hit_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    // R6: a miss answer carries a zero address.
    p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_paddr == '0);

    // R7: a lookup never matches more than one entry.
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hits));

    // R10 and R11: the store is empty in the cycle after a flush.
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> valid_q == '0);
endmodule

bind xlat_tlb xlat_tlb_checker #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .lk_hits   (lk_hits),
    .valid_q   (valid_q)
);

// File: tb/tb_xlat_tlb.sv
`timescale 1ns/1ps
module tb_xlat_tlb;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_vpn = '0;
    logic [15:0] fill_pfn = '0;
    logic [1:0]  fill_perm = '0;
    logic        fill_cacheable = 1'b0;
    logic        fill_bufferable = 1'b0;
    logic        flush = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_cacheable, rsp_bufferable;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_perm;

    always #2 clk = ~clk;

    xlat_tlb dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .fill_cacheable(fill_cacheable), .fill_bufferable(fill_bufferable),
        .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
        .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable)
    );

    // Behavioural reference model.
    int    m_vpn [N];
    int    m_pfn [N];
    int    m_perm[N];
    bit    m_c   [N];
    bit    m_b   [N];
    bit    m_v   [N];
    int    m_rr = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    // Expected response: valid, hit, fault, paddr, perm, c, b
    bit    e_valid = 0, e_hit = 0, e_fault = 0, e_c = 0, e_b = 0;
    int    e_perm = 0;
    logic [31:0] e_paddr = '0;
    string e_tag = "R1";

    task automatic step(input bit lv, input logic [31:0] va, input bit wr,
                        input bit fv, input int fvpn, input int fpfn,
                        input int fperm, input bit fc, input bit fb,
                        input bit fl, input string tag);
        int idx;
        @(negedge clk);
        // Compare the answer to the previous cycle's request.
        checks++;
        if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_fault !== e_fault ||
            rsp_paddr !== e_paddr || rsp_perm !== 2'(e_perm) ||
            rsp_cacheable !== e_c || rsp_bufferable !== e_b) begin
            errors++;
            $display("FAIL %s: got v%0b h%0b f%0b pa=%h p%0d c%0b b%0b exp v%0b h%0b f%0b pa=%h p%0d c%0b b%0b",
                     e_tag, rsp_valid, rsp_hit, rsp_fault, rsp_paddr, rsp_perm,
                     rsp_cacheable, rsp_bufferable, e_valid, e_hit, e_fault,
                     e_paddr, e_perm, e_c, e_b);
        end
        // Drive this cycle's inputs.
        lk_valid = lv; lk_vaddr = va; lk_write = wr;
        fill_valid = fv; fill_vpn = 16'(fvpn); fill_pfn = 16'(fpfn);
        fill_perm = 2'(fperm); fill_cacheable = fc; fill_bufferable = fb;
        flush = fl;
        // Expected answer from the model's current contents.
        e_valid = lv; e_hit = 0; e_fault = 0; e_paddr = '0; e_perm = 0;
        e_c = 0; e_b = 0; e_tag = tag;
        if (lv) begin
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && m_vpn[i] == int'(va[31:16])) begin
                    if ((wr && m_perm[i][1]) || (!wr && m_perm[i][0])) begin
                        e_hit = 1; e_paddr = {16'(m_pfn[i]), va[15:0]};
                        e_perm = m_perm[i]; e_c = m_c[i]; e_b = m_b[i];
                    end else begin
                        e_fault = 1;
                    end
                end
            end
        end
        // Update the model.
        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (fv) begin
            idx = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == fvpn) idx = i;
            if (idx < 0)
                for (int i = N - 1; i >= 0; i--)
                    if (!m_v[i]) idx = i;
            if (idx < 0) begin
                idx = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[idx] = 1; m_vpn[idx] = fvpn; m_pfn[idx] = fpfn;
            m_perm[idx] = fperm; m_c[idx] = fc; m_b[idx] = fb;
        end
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic look(input logic [31:0] va, input bit wr, input string tag);
        step(1, va, wr, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input int vpn, input int pfn, input int perm,
                        input bit c, input bit b, input string tag);
        step(0, '0, 0, 1, vpn, pfn, perm, c, b, 0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset outputs, then a lookup in an empty store.
        idle("R1");
        look(32'h1234_5678, 0, "R1");
        // R4: install a page with attributes.
        fill(16'h1234, 16'hABCD, 3, 1, 0, "R4");
        look(32'h1234_5678, 0, "R3");
        look(32'h1234_FFFF, 1, "R4");
        // R5: read-only, no-access and write-only pages.
        fill(16'h2000, 16'h0042, 1, 0, 1, "R5");
        fill(16'h3000, 16'h0050, 0, 1, 1, "R5");
        fill(16'h3100, 16'h0051, 2, 0, 0, "R5");
        look(32'h2000_0010, 1, "R5");
        look(32'h2000_0010, 0, "R5");
        look(32'h3000_0000, 0, "R5");
        look(32'h3100_0004, 0, "R5");
        look(32'h3100_0004, 1, "R5");
        // R6: miss on an unknown page.
        look(32'h5555_0000, 0, "R6");
        // R2: lookup in the same cycle as its fill misses, next one hits.
        step(1, 32'h4444_0001, 0, 1, 16'h4444, 16'h0777, 3, 1, 1, 0, "R2");
        look(32'h4444_0001, 0, "R2");
        idle("R2");
        // R7: overwrite an existing page.
        fill(16'h1234, 16'h0BEE, 1, 0, 1, "R7");
        look(32'h1234_0AAA, 0, "R7");
        look(32'h1234_0AAA, 1, "R7");
        // R11: flush with a fill in the same cycle.
        step(0, '0, 0, 1, 16'h7777, 16'h0001, 3, 0, 0, 1, "R11");
        look(32'h7777_0000, 0, "R11");
        // R10: earlier pages are gone.
        look(32'h1234_0000, 0, "R10");
        look(32'h2000_0000, 0, "R10");
        // R12: 64 distinct translations all hit.
        for (int i = 0; i < N; i++) fill(16'h0100 + i, 16'h8000 + i, 3, i[0], i[1], "R12");
        for (int i = 0; i < N; i++) look({16'(16'h0100 + i), 16'h0F0F}, 0, "R12");
        // R9: round-robin eviction from entry 0.
        fill(16'h0900, 16'h0900, 3, 0, 0, "R9");
        fill(16'h0901, 16'h0901, 3, 0, 0, "R9");
        look(32'h0100_0000, 0, "R9");
        look(32'h0101_0000, 0, "R9");
        look(32'h0102_0000, 0, "R9");
        look(32'h0900_0000, 0, "R9");
        // R8: after a flush, fills take the lowest free slot; pointer kept.
        step(0, '0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        for (int i = 0; i < N; i++) fill(16'h0200 + i, 16'h4000 + i, 3, 1, 0, "R8");
        fill(16'h0A00, 16'h0A00, 3, 0, 1, "R9");
        look(32'h0202_0000, 0, "R8");
        look(32'h0200_0000, 0, "R8");
        look(32'h0203_0000, 0, "R8");
        look(32'h0A00_1234, 0, "R9");
        idle("R9");
        idle("R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule